// File: doc/BRIEF.md
# Illegal opcode and address reset detector

This block watches the CPU's bus-cycle information and asks for a system reset when the processor tries to run an instruction it must not execute, or when it fetches an instruction from a hole in the memory map. It has two detectors. The opcode detector compares each valid opcode with a parameter list of forbidden codes. It also treats the low-power halt opcode as forbidden whenever the halt-enable configuration bit is clear. The address detector checks each opcode fetch against a set of parameterized base/limit windows. An address that falls in none of the windows counts as unmapped. A data read or write to an unmapped address never counts as an error.

Each detector has its own sticky cause flag, so boot firmware can tell why the system restarted. A detection sets its flag and raises one reset request. The request stays high until the system reset is applied, and while it is high no further detection is taken. Only the power-on reset clears the cause flags.

Top module: `illegal_fetch_guard`

## Requirements
- R1: After a power-on reset (`por_n` low at a clock edge), `rst_req`, `flag_ilop` and `flag_ilad` are all 0.
- R2: When `op_valid` is high and `opcode` matches any entry of the illegal-opcode list, `flag_ilop` and `rst_req` are both 1 after the next clock edge.
- R3: The halt opcode 0x8E with `op_valid` high is illegal when `stop_en` is 0 and gives the R2 response. When `stop_en` is 1 it is legal, unless it also appears in the list.
- R4: A cycle with `bus_valid` and `fetch_cyc` both high whose `bus_addr` is unmapped sets `flag_ilad` and `rst_req` after the next clock edge.
- R5: An address is mapped when base ≤ address ≤ limit holds for at least one configured window (both bounds inclusive). An opcode fetch from a mapped address changes no output.
- R6: A bus cycle with `fetch_cyc` low (data access) to an unmapped address changes no output.
- R7: When `op_valid` is low, `opcode` has no effect. When `bus_valid` is low, `bus_addr` and `fetch_cyc` have no effect.
- R8: When an illegal opcode and an illegal fetch arrive in the same cycle, both flags are set and one reset request is raised.
- R9: Once raised, `rst_req` stays high until `sys_rst_n` is sampled low. It is 0 after that edge.
- R10: While `rst_req` is high, or `sys_rst_n` is low, no new detection is taken and neither flag changes.
- R11: The cause flags hold through a system reset (`sys_rst_n` low). Only `por_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears the request and suspends detection |
| op_valid | input | 1 | Strobe: `opcode` holds an instruction about to execute |
| opcode | input | 8 | Instruction opcode |
| bus_valid | input | 1 | Strobe: a bus cycle is under way at `bus_addr` |
| fetch_cyc | input | 1 | Qualifier: the bus cycle is an opcode fetch |
| bus_addr | input | ADDR_W | Bus cycle address |
| stop_en | input | 1 | Configuration bit: 1 allows the halt opcode 0x8E |
| rst_req | output | 1 | Reset request to the system reset controller |
| flag_ilop | output | 1 | Sticky cause: illegal opcode |
| flag_ilad | output | 1 | Sticky cause: illegal fetch address |

## Verification
The bench builds the block with an 8-bit address and four illegal opcodes (0x31, 0x32, 0x41, 0x9E). It uses three windows, 0x00–0x1F, 0x40–0x7F and 0xF0–0xFF, which leave gaps on both sides of the middle window. With this small setup, all 256 opcodes can be run under both values of `stop_en`, and all 256 addresses as both fetch and data cycles, each from a clean power-on reset. That sweep covers every window edge and the case where 0x8E is illegal only by configuration. Directed sequences then cover simultaneous causes, suppression while a request is pending, and which flags survive which reset.

// File: rtl/ifg_pkg.sv
// ifg_pkg: shared constants and types for the illegal fetch guard.
// Assumes 8-bit opcodes; the halt opcode value is fixed by the instruction set.
package ifg_pkg;
    localparam int OP_W = 8;
    localparam logic [OP_W-1:0] HALT_OPCODE = 8'h8E;

    // Per-cycle verdict of the two detectors.
    typedef struct packed {
        logic bad_op;
        logic bad_addr;
    } ifg_verdict_t;
endpackage

// File: rtl/ifg_opcode_check.sv
// ifg_opcode_check: flags an opcode as illegal when it is in the parameter
// list, or when it is the halt opcode and halt is not enabled.
// Assumes op_valid qualifies opcode; purely combinational.
module ifg_opcode_check
    import ifg_pkg::*;
#(
    parameter int N_ILL = 4,
    parameter logic [N_ILL*OP_W-1:0] ILL_LIST = {8'h9E, 8'h41, 8'h32, 8'h31}
) (
    input  logic            op_valid,
    input  logic [OP_W-1:0] opcode,
    input  logic            stop_en,
    output logic            bad_op
);
    logic [N_ILL-1:0] match;

    // One comparator per listed illegal code.
    for (genvar i = 0; i < N_ILL; i++) begin : g_cmp
        assign match[i] = (opcode == ILL_LIST[i*OP_W +: OP_W]);
    end

    logic halt_blocked;

    // Combine the list match with the configuration-dependent halt rule.
    always_comb begin
        halt_blocked = (opcode == HALT_OPCODE) && !stop_en;
        bad_op       = op_valid && ((|match) || halt_blocked);
    end
endmodule

// File: rtl/ifg_addr_map.sv
// ifg_addr_map: reports whether an address lies inside any configured
// [base, limit] window, both bounds inclusive.
// Assumes base <= limit for every window; windows may overlap.
module ifg_addr_map #(
    parameter int ADDR_W = 16,
    parameter int N_REG  = 3,
    parameter logic [N_REG*ADDR_W-1:0] REG_BASE  = {16'hE000, 16'h8000, 16'h0000},
    parameter logic [N_REG*ADDR_W-1:0] REG_LIMIT = {16'hFFFE, 16'hBFFF, 16'h03FF}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mapped
);
    logic [N_REG-1:0] in_win;

    // Each window: offset from base must not exceed the window span.
    for (genvar i = 0; i < N_REG; i++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = REG_BASE[i*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] SPAN = REG_LIMIT[i*ADDR_W +: ADDR_W] - BASE;
        logic [ADDR_W-1:0] offs;
        assign offs      = addr - BASE;
        assign in_win[i] = (offs <= SPAN);
    end

    // Any window hit makes the address mapped.
    always_comb mapped = |in_win;
endmodule

// File: rtl/illegal_fetch_guard.sv
// illegal_fetch_guard: raises a held reset request and sticky cause flags
// for illegal opcodes and for opcode fetches from unmapped addresses.
// Assumes: por_n clears all state; sys_rst_n low clears the request and
// suspends detection; a pending request also suspends detection.
module illegal_fetch_guard
    import ifg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int N_ILL  = 4,
    parameter logic [N_ILL*OP_W-1:0] ILL_LIST = {8'h9E, 8'h41, 8'h32, 8'h31},
    parameter int N_REG  = 3,
    parameter logic [N_REG*ADDR_W-1:0] REG_BASE  = {16'hE000, 16'h8000, 16'h0000},
    parameter logic [N_REG*ADDR_W-1:0] REG_LIMIT = {16'hFFFE, 16'hBFFF, 16'h03FF}
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic              bus_valid,
    input  logic              fetch_cyc,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              stop_en,
    output logic              rst_req,
    output logic              flag_ilop,
    output logic              flag_ilad
);
    ifg_verdict_t verdict;
    logic         addr_ok;
    logic         armed;

    ifg_opcode_check #(.N_ILL(N_ILL), .ILL_LIST(ILL_LIST)) u_op (
        .op_valid (op_valid),
        .opcode   (opcode),
        .stop_en  (stop_en),
        .bad_op   (verdict.bad_op)
    );

    ifg_addr_map #(.ADDR_W(ADDR_W), .N_REG(N_REG),
                   .REG_BASE(REG_BASE), .REG_LIMIT(REG_LIMIT)) u_map (
        .addr   (bus_addr),
        .mapped (addr_ok)
    );

    // Address verdict only on a confirmed opcode fetch; detection only when armed.
    always_comb begin
        verdict.bad_addr = bus_valid && fetch_cyc && !addr_ok;
        armed            = sys_rst_n && !rst_req;
    end

    // Cause flags and held reset request.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rst_req   <= 1'b0;
            flag_ilop <= 1'b0;
            flag_ilad <= 1'b0;
        end else if (!sys_rst_n) begin
            rst_req   <= 1'b0;
        end else if (armed) begin
            if (verdict.bad_op)   flag_ilop <= 1'b1;
            if (verdict.bad_addr) flag_ilad <= 1'b1;
            if (verdict.bad_op || verdict.bad_addr) rst_req <= 1'b1;
        end
    end

    // R2
    flag_ilop_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_ilop) |-> $rose(rst_req));
    // R4
    flag_ilad_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_ilad) |-> $rose(rst_req));
    // R3
    halt_blocked_chk: assert property (@(posedge clk) disable iff (!por_n)
        (armed && op_valid && opcode == HALT_OPCODE && !stop_en) |=> (rst_req && flag_ilop));
    // R6
    data_access_chk: assert property (@(posedge clk) disable iff (!por_n)
        (armed && bus_valid && !fetch_cyc && !op_valid) |=> !rst_req);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_req && sys_rst_n) |=> rst_req);
    // R9
    req_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> !rst_req);
    // R10
    suppress_chk: assert property (@(posedge clk) disable iff (!por_n)
        !armed |=> ($stable(flag_ilop) && $stable(flag_ilad)));
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (flag_ilop || flag_ilad) |=> ($past(flag_ilop) <= flag_ilop && $past(flag_ilad) <= flag_ilad));
endmodule

// File: tb/illegal_fetch_guard_test.sv
`timescale 1ns/1ps
module illegal_fetch_guard_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, sys_rst_n = 1'b1;
    logic       op_valid = 1'b0, bus_valid = 1'b0, fetch_cyc = 1'b0, stop_en = 1'b0;
    logic [7:0] opcode = 8'h00, bus_addr = 8'h00;
    logic       rst_req, flag_ilop, flag_ilad;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    illegal_fetch_guard #(
        .ADDR_W(8), .N_ILL(4), .ILL_LIST({8'h9E, 8'h41, 8'h32, 8'h31}),
        .N_REG(3), .REG_BASE({8'hF0, 8'h40, 8'h00}), .REG_LIMIT({8'hFF, 8'h7F, 8'h1F})
    ) uut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .op_valid(op_valid),
        .opcode(opcode), .bus_valid(bus_valid), .fetch_cyc(fetch_cyc),
        .bus_addr(bus_addr), .stop_en(stop_en), .rst_req(rst_req),
        .flag_ilop(flag_ilop), .flag_ilad(flag_ilad)
    );

    function automatic bit exp_bad_op(input logic [7:0] op, input logic sen);
        return op == 8'h31 || op == 8'h32 || op == 8'h41 || op == 8'h9E ||
               (op == 8'h8E && !sen);
    endfunction

    function automatic bit exp_mapped(input logic [7:0] a);
        return a <= 8'h1F || (a >= 8'h40 && a <= 8'h7F) || a >= 8'hF0;
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {rst_req, flag_ilop, flag_ilad};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {req,ilop,ilad} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = 0; bus_valid = 0; fetch_cyc = 0;
    endtask

    task automatic por();
        @(negedge clk); idle(); por_n = 0; sys_rst_n = 1;
        @(negedge clk); por_n = 1;
    endtask

    // Drive one cycle at a negedge; outputs are sampled on the following negedge.
    task automatic drive(input logic ov, input logic [7:0] op, input logic bv,
                         input logic fc, input logic [7:0] a, input logic sen);
        op_valid = ov; opcode = op; bus_valid = bv; fetch_cyc = fc;
        bus_addr = a; stop_en = sen;
        @(negedge clk); idle();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        por();
        check("R1", 3'b000);

        // R2 R3 opcode sweep under both halt configurations
        for (int s = 0; s < 2; s++) begin
            for (int op = 0; op < 256; op++) begin
                bit e;
                por();
                drive(1, op[7:0], 0, 0, 8'h00, s[0]);
                e = exp_bad_op(op[7:0], s[0]);
                check(op == 8'h8E ? "R3" : "R2", {e, e, 1'b0});
            end
        end

        // R4 R5 R6 address sweep as fetch and as data access
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 256; a++) begin
                bit e;
                por();
                drive(0, 8'h00, 1, f[0], a[7:0], 1);
                e = f[0] && !exp_mapped(a[7:0]);
                check(f == 0 ? "R6" : (exp_mapped(a[7:0]) ? "R5" : "R4"), {e, 1'b0, e});
            end
        end

        // R7 strobes low: payloads ignored
        por(); drive(0, 8'h31, 0, 1, 8'h30, 0); check("R7", 3'b000);
        por(); drive(0, 8'h8E, 0, 1, 8'hA0, 0); check("R7", 3'b000);

        // R8 both causes in one cycle
        por(); drive(1, 8'h41, 1, 1, 8'h25, 1); check("R8", 3'b111);

        // R9 R10 R11 sequence
        por();
        drive(1, 8'h32, 0, 0, 8'h00, 1); check("R2", 3'b110);
        drive(0, 8'h00, 1, 1, 8'h90, 1); check("R10", 3'b110);
        @(negedge clk); check("R9", 3'b110);
        sys_rst_n = 0; @(negedge clk); check("R9", 3'b010);
        drive(0, 8'h00, 1, 1, 8'h90, 1); check("R10", 3'b010);
        sys_rst_n = 1; @(negedge clk); check("R11", 3'b010);
        drive(0, 8'h00, 1, 1, 8'h90, 1); check("R4", 3'b111);
        sys_rst_n = 0; @(negedge clk); sys_rst_n = 1; check("R11", 3'b011);
        drive(1, 8'h9E, 0, 0, 8'h00, 1); check("R10", 3'b111);
        por(); check("R1", 3'b000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule